// File: doc/BRIEF.md
# Zero-Sequence Injection Modulation Generator

This block turns three sampled, signed phase references into three modulating references for a carrier-based PWM stage. It adds one common offset, the zero-sequence term, to all three phases. The offset depends on the largest and smallest phase value in the current sample, on a half-bus scale `BUS_HALF`, and on a weighting coefficient. The coefficient is held as 0, one half or 1. A 3-bit mode code picks it, either as a fixed value or per sample from a sign test. One datapath therefore covers continuous space-vector modulation and the clamped discontinuous variants. In those variants each modulating wave sits on one bus rail for a total of 120 degrees of each fundamental cycle.

The offset is `BUS_HALF*(2w-1) - w*max + (w-1)*min`, with `w` as the coefficient. For `w=0` this is `-BUS_HALF - min`. For `w=1` it is `BUS_HALF - max`. For `w=1/2` it is `-floor((max+min)/2)`. All arithmetic is integer with shifts and selects, and no multiplier is used. A second, separately supplied set of three references is used only for the sign test of two of the modes. The upstream sine generator pulses `smp_stb` once per sampling period. The results appear one clock later with a one-cycle valid flag.

Top module: `zsi_modgen`

## Requirements
- R1: While `rst_n` is low and after reset, `mod_a`, `mod_b` and `mod_c` are 0 and `mod_vld` is low.
- R2: `mod_vld` is high for exactly the one cycle that follows a cycle with `smp_stb` high. The outputs change only on the clock edge that captures a strobe and hold their values otherwise.
- R3: When no output saturates, `mod_x - ph_x` is the same value for all three phases.
- R4: Mode code 0 (continuous) uses the offset `-floor((max+min)/2)`, where max and min are taken over `ph_a`, `ph_b` and `ph_c`.
- R5: Mode code 1 (minimum clamp) uses the offset `-BUS_HALF - min`, so the smallest output equals `-BUS_HALF`.
- R6: Mode code 2 (maximum clamp) uses the offset `BUS_HALF - max`, so the largest output equals `BUS_HALF`.
- R7: Mode code 3 behaves as code 1 when max+min of the main set is negative, and as code 2 otherwise.
- R8: Mode code 5 applies the opposite rule: it behaves as code 2 when max+min of the main set is negative, and as code 1 otherwise.
- R9: Mode codes 4 and 6 apply the code 3 rule, but to max+min of `aux_a`, `aux_b` and `aux_c`. The offset itself still uses the max and min of the main set.
- R10: Mode code 7 is unused and behaves as code 0.
- R11: Each output saturates to the signed range of `W` bits, which is +32767 and -32768 for `W=16`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_stb | input | 1 | One-cycle sample strobe |
| mode | input | 3 | Modulation mode code (0 to 7) |
| ph_a | input | W | Phase A reference, signed |
| ph_b | input | W | Phase B reference, signed |
| ph_c | input | W | Phase C reference, signed |
| aux_a | input | W | Auxiliary set, phase A, used for the sign test only |
| aux_b | input | W | Auxiliary set, phase B, used for the sign test only |
| aux_c | input | W | Auxiliary set, phase C, used for the sign test only |
| mod_a | output | W | Modulating reference A, signed, saturated |
| mod_b | output | W | Modulating reference B, signed, saturated |
| mod_c | output | W | Modulating reference C, signed, saturated |
| mod_vld | output | 1 | High for one cycle when new outputs are present |

## Verification
The embedded assertions check the following on every cycle:
- the valid flag is a single pulse after each strobe, and the outputs hold between strobes;
- the smallest output lands on `-BUS_HALF` after a minimum-clamp sample;
- the largest output lands on `BUS_HALF` after a maximum-clamp sample;
- in continuous mode the output max plus min is 0 or 1.

The scenarios alone show the sign-driven choice in the four discontinuous modes, including the tests that read the auxiliary set. They also show the fallback of code 7, the floor rounding on odd sums of either sign, and saturation at both rails. The scenarios are chosen so that the main set and the auxiliary set give opposite signs, which tells the two sign sources apart.

// File: rtl/zsi_modgen.sv
module zsi_modgen #(
  parameter int W        = 16,
  parameter int BUS_HALF = 16384
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_stb,
  input  logic [2:0]          mode,
  input  logic signed [W-1:0] ph_a,
  input  logic signed [W-1:0] ph_b,
  input  logic signed [W-1:0] ph_c,
  input  logic signed [W-1:0] aux_a,
  input  logic signed [W-1:0] aux_b,
  input  logic signed [W-1:0] aux_c,
  output logic signed [W-1:0] mod_a,
  output logic signed [W-1:0] mod_b,
  output logic signed [W-1:0] mod_c,
  output logic                mod_vld
);
  localparam int EW = W + 3;
  localparam logic signed [EW-1:0] BH   = EW'(BUS_HALF);
  localparam logic signed [EW-1:0] PMAX = EW'((1 << (W-1)) - 1);
  localparam logic signed [EW-1:0] NMAX = -PMAX - EW'(1);

  function automatic logic signed [W-1:0] max3(input logic signed [W-1:0] x, y, z);
    logic signed [W-1:0] m;
    m = (x > y) ? x : y;
    return (m > z) ? m : z;
  endfunction

  function automatic logic signed [W-1:0] min3(input logic signed [W-1:0] x, y, z);
    logic signed [W-1:0] m;
    m = (x < y) ? x : y;
    return (m < z) ? m : z;
  endfunction

  function automatic logic signed [EW-1:0] ext(input logic signed [W-1:0] x);
    return {{(EW-W){x[W-1]}}, x};
  endfunction

  function automatic logic signed [W-1:0] sat(input logic signed [EW-1:0] v);
    if (v > PMAX) return PMAX[W-1:0];
    if (v < NMAX) return NMAX[W-1:0];
    return v[W-1:0];
  endfunction

  logic signed [EW-1:0] mx, mn, sum_m, sum_x, off;
  logic [1:0] wsel;  // 0: coefficient 0, 1: one half, 2: coefficient 1

  assign mx    = ext(max3(ph_a, ph_b, ph_c));
  assign mn    = ext(min3(ph_a, ph_b, ph_c));
  assign sum_m = mx + mn;
  assign sum_x = ext(max3(aux_a, aux_b, aux_c)) + ext(min3(aux_a, aux_b, aux_c));

  always_comb begin
    case (mode)
      3'd1:           wsel = 2'd0;
      3'd2:           wsel = 2'd2;
      3'd3:           wsel = sum_m[EW-1] ? 2'd0 : 2'd2;
      3'd4, 3'd6:     wsel = sum_x[EW-1] ? 2'd0 : 2'd2;
      3'd5:           wsel = sum_m[EW-1] ? 2'd2 : 2'd0;
      default:        wsel = 2'd1;
    endcase
    case (wsel)
      2'd0:    off = -BH - mn;
      2'd2:    off = BH - mx;
      default: off = -(sum_m >>> 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mod_a   <= '0;
      mod_b   <= '0;
      mod_c   <= '0;
      mod_vld <= 1'b0;
    end else begin
      mod_vld <= smp_stb;
      if (smp_stb) begin
        mod_a <= sat(ext(ph_a) + off);
        mod_b <= sat(ext(ph_b) + off);
        mod_c <= sat(ext(ph_c) + off);
      end
    end
  end

  logic signed [EW-1:0] omx, omn;
  assign omx = ext(max3(mod_a, mod_b, mod_c));
  assign omn = ext(min3(mod_a, mod_b, mod_c));

  assert_valid_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mod_vld |-> $past(smp_stb));
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_stb |=> ($stable(mod_a) && $stable(mod_b) && $stable(mod_c)));
  assert_sv_centre_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_stb && mode == 3'd0) |=> ((omx + omn) == 0 || (omx + omn) == 1));
  assert_min_clamp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_stb && mode == 3'd1) |=> (omn == -BH));
  assert_max_clamp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_stb && mode == 3'd2) |=> (omx == BH));
endmodule

// File: tb/test_zsi_modgen.sv
module test_zsi_modgen;
  localparam int W = 16;
  localparam int BH = 16384;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_stb = 1'b0;
  logic [2:0] mode = 3'd0;
  logic signed [W-1:0] ph_a = '0, ph_b = '0, ph_c = '0;
  logic signed [W-1:0] aux_a = '0, aux_b = '0, aux_c = '0;
  logic signed [W-1:0] mod_a, mod_b, mod_c;
  logic mod_vld;

  int checks = 0;
  int errors = 0;
  logic [3*W-1:0] q_exp[$];
  string q_tag[$];

  always #2.5 clk = ~clk;

  zsi_modgen #(.W(W), .BUS_HALF(BH)) i_zsi_modgen (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .mode(mode),
    .ph_a(ph_a), .ph_b(ph_b), .ph_c(ph_c),
    .aux_a(aux_a), .aux_b(aux_b), .aux_c(aux_c),
    .mod_a(mod_a), .mod_b(mod_b), .mod_c(mod_c), .mod_vld(mod_vld));

  function automatic int satv(input int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic logic [3*W-1:0] model(input int md, a, b, c, xa, xb, xc);
    int mx, mn, xmx, xmn, off, w;
    logic signed [W-1:0] ra, rb, rc;
    mx = a; if (b > mx) mx = b; if (c > mx) mx = c;
    mn = a; if (b < mn) mn = b; if (c < mn) mn = c;
    xmx = xa; if (xb > xmx) xmx = xb; if (xc > xmx) xmx = xc;
    xmn = xa; if (xb < xmn) xmn = xb; if (xc < xmn) xmn = xc;
    case (md)
      1: w = 0;
      2: w = 2;
      3: w = (mx + mn < 0) ? 0 : 2;
      4, 6: w = (xmx + xmn < 0) ? 0 : 2;
      5: w = (mx + mn < 0) ? 2 : 0;
      default: w = 1;
    endcase
    if (w == 0) off = -BH - mn;
    else if (w == 2) off = BH - mx;
    else off = -((mx + mn) >>> 1);
    ra = W'(satv(a + off)); rb = W'(satv(b + off)); rc = W'(satv(c + off));
    return {ra, rb, rc};
  endfunction

  task automatic check(input string tag, input logic [3*W-1:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0d %0d %0d expected %0d %0d %0d", tag,
        $signed(act[3*W-1:2*W]), $signed(act[2*W-1:W]), $signed(act[W-1:0]),
        $signed(exp[3*W-1:2*W]), $signed(exp[2*W-1:W]), $signed(exp[W-1:0]));
    end
  endtask

  task automatic sample(input string tag, input int md, a, b, c,
                        input int xa = 0, xb = 0, xc = 0);
    @(negedge clk);
    mode = 3'(md);
    ph_a = W'(a); ph_b = W'(b); ph_c = W'(c);
    aux_a = W'(xa); aux_b = W'(xb); aux_c = W'(xc);
    smp_stb = 1'b1;
    q_exp.push_back(model(md, a, b, c, xa, xb, xc));
    q_tag.push_back(tag);
    @(negedge clk);
    smp_stb = 1'b0;
  endtask

  // monitor: pops one expected item per valid pulse
  always @(negedge clk) begin
    if (rst_n && mod_vld) begin
      if (q_exp.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2: valid with nothing expected");
      end else begin
        check(q_tag.pop_front(), {mod_a, mod_b, mod_c}, q_exp.pop_front());
      end
    end
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: run hung");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [3*W-1:0] held;
    repeat (3) @(negedge clk);
    check("R1 reset", {mod_a, mod_b, mod_c}, '0);
    check("R1 valid", {47'd0, mod_vld}, '0);
    rst_n = 1'b1;
    @(negedge clk);

    sample("R4 R3 continuous", 0, 1000, -200, -800);
    sample("R4 odd positive sum", 0, 5, -2, 0);
    sample("R4 odd negative sum", 0, -5, 2, 0);
    sample("R5 min clamp", 1, 1000, -200, -800);
    sample("R6 max clamp", 2, 1000, -200, -800);
    sample("R7 sum >= 0", 3, 1000, -200, -800);
    sample("R7 sum < 0", 3, -1000, 200, 800);
    sample("R8 sum >= 0", 5, 1000, -200, -800);
    sample("R8 sum < 0", 5, -1000, 200, 800);
    sample("R9 code4 aux negative", 4, 1000, -200, -800, -900, 100, 300);
    sample("R9 code4 aux positive", 4, -1000, 200, 800, 900, -100, -300);
    sample("R9 code6 aux negative", 6, 1000, -200, -800, -900, 100, 300);
    sample("R10 code7 fallback", 7, 1000, -200, -800);
    sample("R11 low rail", 2, 30000, -30000, 0);
    sample("R11 high rail", 1, 30000, -20000, 0);

    repeat (2) @(negedge clk);
    held = {mod_a, mod_b, mod_c};
    ph_a = 16'sd123; mode = 3'd2;
    repeat (3) @(negedge clk);
    check("R2 hold without strobe", {mod_a, mod_b, mod_c}, held);
    check("R2 valid low", {47'd0, mod_vld}, '0);
    check("R2 queue drained", 48'(q_exp.size()), '0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule